// File: doc/BRIEF.md
# PWM Event-Trigger Prescaler

This block sits beside a PWM time base and converts its event pulses into two kinds of request: an interrupt request for the processor and a start-of-conversion (SOC) request for an ADC. Each request type is a separate channel. A channel has its own source selection, its own 4-bit event counter and its own prescale setting. The time base supplies single-cycle pulses for counter-equals-zero, counter-equals-period and counter-equals-compare. A digital-compare stage supplies a further event pulse, and a sync pulse can also arrive.

A channel counts the qualifying events and issues a one-cycle request pulse when the count reaches the programmed prescale value N, for N from 1 to 15. Selecting zero-or-period as the source gives one request on each edge of an up-down carrier. Software can preload the counters on a sync pulse. It can also force a request or clear the sticky flag that records one. The interrupt channel stops pulsing while its flag is set. The SOC channel keeps pulsing whatever its flag holds.

Top module: `pwm_evt_trig`

## Requirements
- R1: Source select codes 1, 2 and 3 qualify, in that order, a zero event, a period event, and a zero or a period event. Code 0, 6 and 7 qualify nothing.
- R2: Code 4 qualifies a compare event on both channels. Code 5 qualifies a digital-compare event on the SOC channel only. On the interrupt channel code 5 qualifies nothing.
- R3: With prescale N in 1..15, a request pulse is issued by the qualifying event that brings the count to N or above. The counter then returns to 0.
- R4: Prescale 0 disables event-driven requests on that channel and holds its counter at 0. Sync loads and events have no effect on it.
- R5: When sync_load_en is high and a sync pulse arrives, the counters of the enabled channels take the values int_init and soc_init. An event in the same cycle is not counted.
- R6: The event counter is visible on int_cnt and soc_cnt. It saturates at 15 and does not wrap.
- R7: Each request sets the channel's sticky flag. While the interrupt flag is set, events issue no interrupt pulse and the counter keeps counting. Whether the flag blocks is judged on its value before the current edge.
- R8: The SOC channel issues its pulse on every Nth event whether or not soc_flag is set.
- R9: A force strobe gives one request pulse in the next cycle and sets the flag. It ignores prescale, counter and flag, and leaves the counter unchanged.
- R10: A clear strobe resets the flag. An issued or forced request in the same cycle wins, and the flag stays set.
- R11: Request pulses last exactly one cycle and appear in the cycle after the triggering input. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_zero | input | 1 | Counter-equals-zero pulse |
| evt_prd | input | 1 | Counter-equals-period pulse |
| evt_cmp | input | 1 | Counter-equals-compare pulse |
| evt_dc | input | 1 | Digital-compare event pulse |
| sync_in | input | 1 | Sync pulse |
| sync_load_en | input | 1 | Enables counter preload on sync |
| int_sel | input | 3 | Interrupt source select |
| int_prd | input | 4 | Interrupt prescale (0 disables) |
| int_init | input | 4 | Interrupt counter preload value |
| int_clr | input | 1 | Interrupt flag clear strobe |
| int_frc | input | 1 | Interrupt force strobe |
| soc_sel | input | 3 | SOC source select |
| soc_prd | input | 4 | SOC prescale (0 disables) |
| soc_init | input | 4 | SOC counter preload value |
| soc_clr | input | 1 | SOC flag clear strobe |
| soc_frc | input | 1 | SOC force strobe |
| int_pulse | output | 1 | Interrupt request pulse |
| int_flag | output | 1 | Interrupt sticky flag |
| int_cnt | output | 4 | Interrupt event counter |
| soc_pulse | output | 1 | SOC request pulse |
| soc_flag | output | 1 | SOC sticky flag |
| soc_cnt | output | 4 | SOC event counter |

## Verification
Directed phases drive each source code against all four event kinds. This shows that zero, period, zero-or-period, compare and digital-compare qualify exactly their own pulses, and that code 5 does not qualify on the interrupt channel. Prescale values of 1, 3 and 0 are tried to separate the "every event", "every Nth" and "disabled" behaviours. A held interrupt flag with a stream of events shows both the pulse blocking and the saturation at 15. The same stream on SOC shows that SOC does not block. Random phases mix events, syncs with preload, clears and forces in the same cycles to exercise the priority rules, and every output is checked each cycle.

// File: rtl/pwm_et_pkg.sv
package pwm_et_pkg;
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_ZERO = 3'd1,
        SRC_PRD  = 3'd2,
        SRC_ZP   = 3'd3,
        SRC_CMP  = 3'd4,
        SRC_DC   = 3'd5
    } src_e;

    localparam int SEL_W = 3;
endpackage

// File: rtl/pwm_et_src.sv
module pwm_et_src
    import pwm_et_pkg::*;
#(
    parameter bit ALLOW_DC = 1'b0
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             zero_i,
    input  logic             prd_i,
    input  logic             cmp_i,
    input  logic             dc_i,
    output logic             hit_o
);
    logic dc_hit;

    generate
        if (ALLOW_DC) begin : g_dc
            assign dc_hit = dc_i;
        end else begin : g_no_dc
            assign dc_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (sel_i)
            SRC_ZERO: hit_o = zero_i;
            SRC_PRD:  hit_o = prd_i;
            SRC_ZP:   hit_o = zero_i | prd_i;
            SRC_CMP:  hit_o = cmp_i;
            SRC_DC:   hit_o = dc_hit;
            default:  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_et_chan.sv
module pwm_et_chan #(
    parameter int CNT_W  = 4,
    parameter bit STICKY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             sync_ld_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic [CNT_W-1:0] prd_i,
    input  logic             clr_i,
    input  logic             frc_i,
    output logic             pulse_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             flag;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             blocked;
    logic             issue;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        issue      = 1'b0;
        cnt_inc    = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        blocked    = STICKY && st_q.flag;
        if (prd_i == '0) begin
            st_d.cnt = '0;
        end else if (sync_ld_i) begin
            st_d.cnt = init_i;
        end else if (hit_i) begin
            if (cnt_inc >= prd_i && !blocked) begin
                issue    = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (issue || frc_i) begin
            st_d.pulse = 1'b1;
            st_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign flag_o  = st_q.flag;
    assign cnt_o   = st_q.cnt;

    // R4: a disabled channel keeps its counter at zero
    p_off_cnt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prd_i == '0) |-> (cnt_o == '0));

    // R4: with prescale 0 only a force can produce a pulse
    p_off_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prd_i == '0) && !$past(frc_i)) |-> !pulse_o);

    // R5: a sync preload lands in the counter
    p_sync_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_ld_i) && $past(prd_i != '0)) |-> (cnt_o == $past(init_i)));

    // R9: a force always gives a pulse
    p_force_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frc_i) |-> (pulse_o && flag_o));

    // R7: every pulse leaves the flag set
    p_pulse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> flag_o);

    // R3: an event-driven request leaves the counter at zero
    p_issue_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !$past(frc_i)) |-> (cnt_o == '0));

    generate
        if (STICKY) begin : g_sticky_chk
            // R7: a held flag blocks event-driven pulses
            p_sticky_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(flag_o) && !$past(frc_i)) |-> !pulse_o);
        end
    endgenerate
endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
    import pwm_et_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_zero,
    input  logic             evt_prd,
    input  logic             evt_cmp,
    input  logic             evt_dc,
    input  logic             sync_in,
    input  logic             sync_load_en,
    input  logic [2:0]       int_sel,
    input  logic [CNT_W-1:0] int_prd,
    input  logic [CNT_W-1:0] int_init,
    input  logic             int_clr,
    input  logic             int_frc,
    input  logic [2:0]       soc_sel,
    input  logic [CNT_W-1:0] soc_prd,
    input  logic [CNT_W-1:0] soc_init,
    input  logic             soc_clr,
    input  logic             soc_frc,
    output logic             int_pulse,
    output logic             int_flag,
    output logic [CNT_W-1:0] int_cnt,
    output logic             soc_pulse,
    output logic             soc_flag,
    output logic [CNT_W-1:0] soc_cnt
);
    localparam int NCH = 2;
    localparam bit [NCH-1:0] CH_DC     = 2'b10;
    localparam bit [NCH-1:0] CH_STICKY = 2'b01;

    logic [NCH-1:0][SEL_W-1:0] sel_a;
    logic [NCH-1:0][CNT_W-1:0] prd_a, init_a, cnt_a;
    logic [NCH-1:0]            clr_a, frc_a, hit_a, pulse_a, flag_a;
    logic                      sync_ld;

    assign sync_ld = sync_in & sync_load_en;
    assign sel_a   = {soc_sel, int_sel};
    assign prd_a   = {soc_prd, int_prd};
    assign init_a  = {soc_init, int_init};
    assign clr_a   = {soc_clr, int_clr};
    assign frc_a   = {soc_frc, int_frc};

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            pwm_et_src #(.ALLOW_DC(CH_DC[i])) u_src (
                .sel_i  (sel_a[i]),
                .zero_i (evt_zero),
                .prd_i  (evt_prd),
                .cmp_i  (evt_cmp),
                .dc_i   (evt_dc),
                .hit_o  (hit_a[i])
            );
            pwm_et_chan #(.CNT_W(CNT_W), .STICKY(CH_STICKY[i])) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .hit_i     (hit_a[i]),
                .sync_ld_i (sync_ld),
                .init_i    (init_a[i]),
                .prd_i     (prd_a[i]),
                .clr_i     (clr_a[i]),
                .frc_i     (frc_a[i]),
                .pulse_o   (pulse_a[i]),
                .flag_o    (flag_a[i]),
                .cnt_o     (cnt_a[i])
            );
        end
    endgenerate

    assign int_pulse = pulse_a[0];
    assign int_flag  = flag_a[0];
    assign int_cnt   = cnt_a[0];
    assign soc_pulse = pulse_a[1];
    assign soc_flag  = flag_a[1];
    assign soc_cnt   = cnt_a[1];

    // R11: request pulses never last two cycles
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_pulse) && !$past(int_frc)) |-> !int_pulse);

    // R2: digital-compare events never drive the interrupt channel
    p_int_no_dc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_sel == 3'd5) && !$past(int_frc) && !$past(sync_ld)
         && $past(int_prd != '0)) |-> (int_cnt == $past(int_cnt)));
endmodule

// File: tb/pwm_evt_trig_tb.sv
module pwm_evt_trig_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_zero = 0, evt_prd = 0, evt_cmp = 0, evt_dc = 0, sync_in = 0, sync_load_en = 0;
    logic [2:0] int_sel = 0, soc_sel = 0;
    logic [3:0] int_prd = 0, int_init = 0, soc_prd = 0, soc_init = 0;
    logic int_clr = 0, int_frc = 0, soc_clr = 0, soc_frc = 0;
    logic int_pulse, int_flag, soc_pulse, soc_flag;
    logic [3:0] int_cnt, soc_cnt;

    int total = 0;
    int bad = 0;
    string cur_req = "R11";

    logic [3:0] m_cnt [2];
    logic       m_flag [2];
    logic       m_pulse [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_evt_trig u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_zero(evt_zero), .evt_prd(evt_prd), .evt_cmp(evt_cmp), .evt_dc(evt_dc),
        .sync_in(sync_in), .sync_load_en(sync_load_en),
        .int_sel(int_sel), .int_prd(int_prd), .int_init(int_init),
        .int_clr(int_clr), .int_frc(int_frc),
        .soc_sel(soc_sel), .soc_prd(soc_prd), .soc_init(soc_init),
        .soc_clr(soc_clr), .soc_frc(soc_frc),
        .int_pulse(int_pulse), .int_flag(int_flag), .int_cnt(int_cnt),
        .soc_pulse(soc_pulse), .soc_flag(soc_flag), .soc_cnt(soc_cnt)
    );

    function automatic logic qualifies(input logic [2:0] s, input bit dc_ok);
        case (s)
            3'd1: return evt_zero;
            3'd2: return evt_prd;
            3'd3: return evt_zero | evt_prd;
            3'd4: return evt_cmp;
            3'd5: return dc_ok ? evt_dc : 1'b0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_ch(input int c, input logic [2:0] s, input logic [3:0] n,
                            input logic [3:0] ini, input logic clr, input logic frc);
        logic hit;
        logic [4:0] nx;
        logic iss;
        hit = qualifies(s, c == 1);
        iss = 1'b0;
        if (n == 0) m_cnt[c] = 0;
        else if (sync_in && sync_load_en) m_cnt[c] = ini;
        else if (hit) begin
            nx = (m_cnt[c] == 4'd15) ? 5'd15 : {1'b0, m_cnt[c]} + 5'd1;
            if (nx >= {1'b0, n} && !(c == 0 && m_flag[c])) begin
                iss = 1'b1;
                m_cnt[c] = 0;
            end else m_cnt[c] = nx[3:0];
        end
        if (clr) m_flag[c] = 1'b0;
        m_pulse[c] = iss | frc;
        if (iss | frc) m_flag[c] = 1'b1;
    endtask

    task automatic chk(input string what, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("int_pulse", {3'b0, int_pulse}, {3'b0, m_pulse[0]});
        chk("int_flag",  {3'b0, int_flag},  {3'b0, m_flag[0]});
        chk("int_cnt",   int_cnt, m_cnt[0]);
        chk("soc_pulse", {3'b0, soc_pulse}, {3'b0, m_pulse[1]});
        chk("soc_flag",  {3'b0, soc_flag},  {3'b0, m_flag[1]});
        chk("soc_cnt",   soc_cnt, m_cnt[1]);
    endtask

    // one clock: inputs already driven, model updated, outputs compared off-edge
    task automatic step();
        @(posedge clk);
        model_ch(0, int_sel, int_prd, int_init, int_clr, int_frc);
        model_ch(1, soc_sel, soc_prd, soc_init, soc_clr, soc_frc);
        #(CLK_PERIOD/4);
        check_all();
        {evt_zero, evt_prd, evt_cmp, evt_dc, sync_in} = '0;
        {int_clr, int_frc, soc_clr, soc_frc} = '0;
    endtask

    task automatic ev(input logic z, input logic p, input logic c, input logic d);
        evt_zero = z; evt_prd = p; evt_cmp = c; evt_dc = d;
        step();
    endtask

    task automatic clear_both();
        int_clr = 1; soc_clr = 1;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_flag[c] = 0; m_pulse[c] = 0;
        end
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        cur_req = "R11";
        check_all();
        rst_n = 1'b1;
        step();

        // R1: zero / period / both / none codes
        cur_req = "R1";
        int_prd = 1; soc_prd = 1;
        for (int s = 0; s < 8; s++) begin
            if (s == 4 || s == 5) continue;
            int_sel = s[2:0]; soc_sel = s[2:0];
            ev(1, 0, 0, 0); clear_both();
            ev(0, 1, 0, 0); clear_both();
            ev(0, 0, 1, 1); clear_both();
        end

        // R2: compare on both, digital compare on SOC only
        cur_req = "R2";
        int_sel = 4; soc_sel = 4;
        ev(0, 0, 1, 0); clear_both();
        ev(0, 0, 0, 1); clear_both();
        int_sel = 5; soc_sel = 5; int_prd = 2; soc_prd = 2;
        ev(0, 0, 0, 1); ev(0, 0, 0, 1); clear_both();
        ev(0, 0, 1, 0); ev(1, 1, 0, 0);

        // R3: every third event
        cur_req = "R3";
        int_sel = 1; soc_sel = 1; int_prd = 3; soc_prd = 3;
        clear_both();
        for (int k = 0; k < 7; k++) begin
            ev(1, 0, 0, 0);
            ev(0, 1, 0, 0);
            if (k % 3 == 2) clear_both();
        end

        // R4: disabled channels
        cur_req = "R4";
        int_prd = 0; soc_prd = 0; sync_load_en = 1;
        int_init = 7; soc_init = 9;
        for (int k = 0; k < 4; k++) ev(1, 1, 1, 1);
        sync_in = 1; step();

        // R5: sync preload, event in same cycle ignored
        cur_req = "R5";
        int_prd = 3; soc_prd = 3; int_init = 2; soc_init = 1;
        sync_in = 1; evt_zero = 1; step();
        ev(1, 0, 0, 0); ev(1, 0, 0, 0);
        int_init = 14; soc_init = 12; sync_in = 1; step();
        ev(1, 0, 0, 0);
        sync_load_en = 0; sync_in = 1; step();
        clear_both();

        // R6 and R7: held interrupt flag blocks pulses, counter saturates
        cur_req = "R7";
        int_prd = 2; soc_prd = 2;
        ev(1, 0, 0, 0); ev(1, 0, 0, 0);
        for (int k = 0; k < 18; k++) begin
            cur_req = (k < 10) ? "R7" : "R6";
            ev(1, 0, 0, 0);
        end
        cur_req = "R8";
        for (int k = 0; k < 4; k++) ev(1, 0, 0, 0);
        cur_req = "R7";
        int_clr = 1; evt_zero = 1; step();
        ev(1, 0, 0, 0);

        // R9: force bypasses prescale, flag and disable
        cur_req = "R9";
        clear_both();
        int_frc = 1; soc_frc = 1; step();
        int_frc = 1; step();
        int_prd = 0; soc_prd = 0; soc_frc = 1; int_frc = 1; step();

        // R10: clear versus force / issue in the same cycle
        cur_req = "R10";
        int_clr = 1; int_frc = 1; soc_clr = 1; step();
        int_prd = 1; soc_prd = 1;
        clear_both();
        ev(1, 0, 0, 0);
        soc_clr = 1; evt_zero = 1; step();
        soc_clr = 1; step();

        // random mixture
        cur_req = "R3 R7 R8";
        for (int k = 0; k < 4000; k++) begin
            if (($urandom % 64) == 0) begin
                int_sel = 3'($urandom); soc_sel = 3'($urandom);
                int_prd = (($urandom % 6) == 0) ? 4'd0 : 4'($urandom % 5 + 1);
                soc_prd = (($urandom % 6) == 0) ? 4'd0 : 4'($urandom % 5 + 1);
                int_init = 4'($urandom); soc_init = 4'($urandom);
                sync_load_en = 1'($urandom);
            end
            evt_zero = (($urandom % 3) == 0);
            evt_prd  = (($urandom % 3) == 0);
            evt_cmp  = (($urandom % 4) == 0);
            evt_dc   = (($urandom % 4) == 0);
            sync_in  = (($urandom % 20) == 0);
            int_clr  = (($urandom % 6) == 0);
            soc_clr  = (($urandom % 6) == 0);
            int_frc  = (($urandom % 40) == 0);
            soc_frc  = (($urandom % 40) == 0);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule